// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks which page frame to give up when memory is full. It keeps one reference bit per frame and a circular hand pointer. Every access sets the bit of the frame it touches. The hand does not move on accesses. It moves only when an eviction is requested.

On a request, a small state machine walks the frames one per clock, starting at the hand. A frame with its bit set gets the bit cleared and is passed over; this is its second chance. The first frame found with a clear bit becomes the victim. Its index is presented together with a one-cycle done pulse, and the hand is left one frame past the victim.

If every bit is set, one full turn clears them all and the starting frame is chosen. In that case the order of eviction falls back to first-in-first-out. The walk is bounded, so a stream of accesses arriving during a scan cannot stall it.

Top module: `clk_sc_victim_sel`

## Requirements
- R1: After reset, all reference bits are clear, the hand points at frame 0 and `victim_vld_o` is low. The first eviction therefore returns frame 0.
- R2: A cycle with `acc_vld_i` high sets the reference bit of frame `acc_idx_i`. Accesses never move the hand.
- R3: A request is captured on a rising edge while the selector is idle. The scan then examines frames in order from the hand, and the first frame with a clear bit is the victim. `victim_vld_o` is high for exactly one cycle, with the victim index on `victim_idx_o`.
- R4: A frame examined with its bit set is skipped and its bit is cleared, so a later scan can choose it.
- R5: After frame N-1 the scan continues at frame 0.
- R6: If all N bits are set when the scan starts, the scan skips N frames, clearing all of them, and returns the frame where it started.
- R7: After each eviction the hand points at (victim + 1) mod N, and the next scan starts there.
- R8: An access to the frame being examined, in the same cycle, takes priority over clearing. That frame is skipped and its bit stays set, except on the final permitted examination (see R10).
- R9: An eviction request that arrives while a scan is in progress is ignored. It produces no second victim and does not move the hand.
- R10: A scan examines at most N+1 frames. On the (N+1)-th examination the frame under the hand is chosen, even if an access hits it in that cycle.
- R11: If k frames are skipped, `victim_vld_o` rises k+1 clock cycles after the edge that captured the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_vld_i | input | 1 | A frame was referenced this cycle |
| acc_idx_i | input | IW | Index of the referenced frame |
| evict_req_i | input | 1 | Request a victim; taken only when idle |
| victim_vld_o | output | 1 | One-cycle pulse: victim index is valid |
| victim_idx_o | output | IW | Index of the chosen frame |

## Verification
The hardest case to reach is an access that lands on the exact frame under examination in the same clock. It is harder still when that examination is the final forced one at the end of a full revolution. The bench handles this by putting the access cycle, counted from the request, into the eviction task. It predicts which frame the hand is on in each cycle from the known hand position and the set bits. The case where a bit survives a same-cycle hit is confirmed later: a run of further evictions walks the hand back to that frame and shows it being skipped once more.

// File: rtl/clk_sc_pkg.sv
package clk_sc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_st_e;

endpackage

// File: rtl/clk_sc_refbits.sv
module clk_sc_refbits #(
  parameter int NF = 8,
  parameter int IW = $clog2(NF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_en_i,
  input  logic [IW-1:0] set_idx_i,
  input  logic          clr_en_i,
  input  logic [IW-1:0] clr_idx_i,
  output logic [NF-1:0] bits_o
);

  logic [NF-1:0] bits_q;
  logic [NF-1:0] bits_d;

  for (genvar g = 0; g < NF; g++) begin : g_frame
    logic hit_set;
    logic hit_clr;
    assign hit_set = set_en_i && (set_idx_i == IW'(g));
    assign hit_clr = clr_en_i && (clr_idx_i == IW'(g));

    // a set in the same cycle beats a clear of the same frame
    always_comb begin
      bits_d[g] = bits_q[g];
      if (hit_set)      bits_d[g] = 1'b1;
      else if (hit_clr) bits_d[g] = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                bits_q[g] <= 1'b0;
      else if (hit_set || hit_clr) bits_q[g] <= bits_d[g];
    end
  end

  assign bits_o = bits_q;

  a_r2_access_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> bits_q[$past(set_idx_i)]);

  a_r4_skip_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !(set_en_i && set_idx_i == clr_idx_i)) |=> !bits_q[$past(clr_idx_i)]);

  a_r8_hit_keeps_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && set_en_i && set_idx_i == clr_idx_i) |=> bits_q[$past(clr_idx_i)]);

endmodule

// File: rtl/clk_sc_hand.sv
module clk_sc_hand #(
  parameter int NF = 8,
  parameter int IW = $clog2(NF),
  parameter int CW = $clog2(NF + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          step_i,
  input  logic          commit_i,
  output logic [IW-1:0] hand_o,
  output logic [IW-1:0] ptr_o,
  output logic          last_o
);

  logic [IW-1:0] hand_q, hand_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] ptr_inc;

  assign ptr_inc = (ptr_q == IW'(NF - 1)) ? '0 : ptr_q + IW'(1);

  always_comb begin
    hand_d = hand_q;
    ptr_d  = ptr_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      ptr_d = hand_q;
      cnt_d = '0;
    end else if (step_i) begin
      ptr_d = ptr_inc;
      cnt_d = cnt_q + CW'(1);
    end
    if (commit_i) hand_d = ptr_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hand_q <= '0;
      ptr_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (commit_i)           hand_q <= hand_d;
      if (start_i || step_i) begin
        ptr_q <= ptr_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign hand_o = hand_q;
  assign ptr_o  = ptr_q;
  assign last_o = (cnt_q == CW'(NF));

  a_r2_hand_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(hand_q));

endmodule

// File: rtl/clk_sc_ctrl.sv
module clk_sc_ctrl #(
  parameter int NF = 8,
  parameter int IW = $clog2(NF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evict_req_i,
  input  logic          seen_i,
  input  logic          last_i,
  input  logic [IW-1:0] ptr_i,
  output logic          start_o,
  output logic          step_o,
  output logic          commit_o,
  output logic          clr_en_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [IW-1:0] victim_o
);

  import clk_sc_pkg::*;

  scan_st_e      st_q, st_d;
  logic          done_q, done_d;
  logic [IW-1:0] vic_q, vic_d;
  logic          pick;

  always_comb begin
    st_d     = st_q;
    done_d   = 1'b0;
    vic_d    = vic_q;
    start_o  = 1'b0;
    step_o   = 1'b0;
    commit_o = 1'b0;
    clr_en_o = 1'b0;
    pick     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (evict_req_i) begin
          start_o = 1'b1;
          st_d    = ST_SCAN;
        end
      end
      ST_SCAN: begin
        pick = !seen_i || last_i;
        if (pick) begin
          commit_o = 1'b1;
          done_d   = 1'b1;
          vic_d    = ptr_i;
          st_d     = ST_IDLE;
        end else begin
          step_o   = 1'b1;
          clr_en_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      vic_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (done_d) vic_q <= vic_d;
    end
  end

  assign busy_o   = (st_q == ST_SCAN);
  assign done_o   = done_q;
  assign victim_o = vic_q;

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  a_r9_req_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !pick) |=> (busy_o && !done_q));

endmodule

// File: rtl/clk_sc_victim_sel.sv
module clk_sc_victim_sel #(
  parameter int NF = 8,
  parameter int IW = $clog2(NF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_vld_i,
  input  logic [IW-1:0] acc_idx_i,
  input  logic          evict_req_i,
  output logic          victim_vld_o,
  output logic [IW-1:0] victim_idx_o
);

  localparam int CW = $clog2(NF + 1);
  localparam int SW = $clog2(NF + 2);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [NF-1:0] ref_bits;
  logic [IW-1:0] hand;
  logic [IW-1:0] ptr;
  logic          last;
  logic          start, step, commit, clr_en, busy;
  logic          hit, seen;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign hit  = acc_vld_i && (acc_idx_i == ptr);
  assign seen = ref_bits[ptr] || hit;

  clk_sc_refbits #(.NF(NF), .IW(IW)) u_bits (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .set_en_i  (acc_vld_i),
    .set_idx_i (acc_idx_i),
    .clr_en_i  (clr_en),
    .clr_idx_i (ptr),
    .bits_o    (ref_bits)
  );

  clk_sc_hand #(.NF(NF), .IW(IW), .CW(CW)) u_hand (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .start_i  (start),
    .step_i   (step),
    .commit_i (commit),
    .hand_o   (hand),
    .ptr_o    (ptr),
    .last_o   (last)
  );

  clk_sc_ctrl #(.NF(NF), .IW(IW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .evict_req_i (evict_req_i),
    .seen_i      (seen),
    .last_i      (last),
    .ptr_i       (ptr),
    .start_o     (start),
    .step_o      (step),
    .commit_o    (commit),
    .clr_en_o    (clr_en),
    .busy_o      (busy),
    .done_o      (victim_vld_o),
    .victim_o    (victim_idx_o)
  );

  // checker state: examinations in the current scan
  logic [SW-1:0] scan_cyc_q;
  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n)                          scan_cyc_q <= '0;
    else if (!busy)                          scan_cyc_q <= '0;
    else if (scan_cyc_q != SW'(NF + 1))      scan_cyc_q <= scan_cyc_q + SW'(1);
  end

  a_r10_scan_bound: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    busy |-> (scan_cyc_q <= SW'(NF)));

  a_r7_hand_after_victim: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    victim_vld_o |-> (hand == ((victim_idx_o == IW'(NF - 1)) ? '0 : victim_idx_o + IW'(1))));

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> !victim_vld_o);

endmodule

// File: tb/clk_sc_victim_sel_tb_top.sv
module clk_sc_victim_sel_tb_top;

  localparam int NF = 8;
  localparam int IW = $clog2(NF);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_vld = 1'b0;
  logic [IW-1:0] acc_idx = '0;
  logic          evict_req = 1'b0;
  logic          vic_vld;
  logic [IW-1:0] vic_idx;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    int    idx;
    int    lat;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  clk_sc_victim_sel #(.NF(NF), .IW(IW)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .acc_vld_i    (acc_vld),
    .acc_idx_i    (acc_idx),
    .evict_req_i  (evict_req),
    .victim_vld_o (vic_vld),
    .victim_idx_o (vic_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: latency counted in falling edges from the one that saw the request
  bit inflight = 1'b0;
  int lat = 0;
  always @(negedge clk) begin
    if (evict_req && !inflight) begin
      inflight = 1'b1;
      lat = 0;
    end else if (inflight) begin
      lat++;
    end
    if (vic_vld) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R3 R9 unexpected victim pulse", int'(vic_idx), -1);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(int'(vic_idx) == e.idx, {e.tag, " victim index"}, int'(vic_idx), e.idx);
        chk(lat == e.lat, {e.tag, " R11 latency"}, lat, e.lat);
      end
      inflight = 1'b0;
    end
  end

  task automatic touch(input int idx);
    @(posedge clk); #2;
    acc_vld = 1'b1;
    acc_idx = IW'(idx);
    @(posedge clk); #2;
    acc_vld = 1'b0;
  endtask

  task automatic touch_all();
    for (int i = 0; i < NF; i++) touch(i);
  endtask

  // skipped: frames passed over; hit_step/hit_idx: same-cycle access;
  // rereq_step: a second request while scanning
  task automatic evict(input int exp_idx, input int skipped, input int hit_step,
                       input int hit_idx, input int rereq_step, input string tag);
    exp_t e;
    e.idx = exp_idx;
    e.lat = skipped + 2;
    e.tag = tag;
    @(posedge clk); #2;
    sb_q.push_back(e);
    evict_req = 1'b1;
    @(posedge clk); #2;
    evict_req = 1'b0;
    for (int s = 0; s < NF + 2; s++) begin
      acc_vld   = (s == hit_step);
      acc_idx   = IW'(hit_idx);
      evict_req = (s == rereq_step);
      @(posedge clk); #2;
    end
    acc_vld   = 1'b0;
    evict_req = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(vic_vld == 1'b0, "R1 pulse low in reset", int'(vic_vld), 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #5;
    chk(vic_vld == 1'b0, "R1 pulse low after reset", int'(vic_vld), 0);
    chk(vic_idx == '0, "R1 index after reset", int'(vic_idx), 0);

    evict(0, 0, -1, 0, -1, "R1 first eviction");
    touch(1); touch(2); touch(3);
    evict(4, 3, -1, 0, -1, "R2 R4 skip set frames");
    touch(5); touch(6); touch(7);
    evict(0, 3, -1, 0, -1, "R5 wrap to frame 0");
    evict(1, 0, -1, 0, -1, "R7 hand past victim");
    touch_all();
    evict(2, 8, -1, 0, -1, "R6 all set, fifo fallback");
    touch(4);
    evict(5, 2, 0, 3, -1, "R8 same-cycle hit skipped");
    evict(6, 0, -1, 0, -1, "R7 walk");
    evict(7, 0, -1, 0, -1, "R7 walk");
    evict(0, 0, -1, 0, -1, "R5 walk");
    evict(1, 0, -1, 0, -1, "R7 walk");
    evict(2, 0, -1, 0, -1, "R7 walk");
    evict(4, 1, -1, 0, -1, "R8 hit bit stayed set");
    evict(5, 0, -1, 0, 0, "R9 request while scanning");
    evict(6, 0, -1, 0, -1, "R9 hand not moved twice");
    touch_all();
    evict(7, 8, 8, 7, -1, "R10 forced pick on last exam");
    evict(0, 0, -1, 0, -1, "R3 after forced pick");

    repeat (4) @(posedge clk);
    #2;
    chk(sb_q.size() == 0, "R3 all expected victims seen", sb_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule